// File: doc/BRIEF.md
# Transport Stream PID Filter

This block screens a byte-parallel MPEG transport stream of fixed-length packets (188 bytes by default). A start strobe marks the first byte of each packet and a valid strobe qualifies every byte. The block takes the 13-bit packet identifier from the header and checks it against several sources. The first is six dedicated identifier registers, each with its own enable. The second is a masked group compare. The third is an indexed table of identifier slots, each slot with its own enable bit. A packet that any enabled source accepts is forwarded whole. Every other packet is removed from the stream.

The decision is taken when the third header byte arrives. Until then the header bytes wait in a small hold queue. If the packet passes they are released ahead of the payload. If it is dropped they are taken back off the queue. No partial packet ever reaches the output. A master receive enable, a null-packet filter, a sync-byte test and the transport-error bit can each veto a packet. The transport-error bit also sets a sticky flag. The table is loaded through a two-step port: an index strobe selects a slot, and a data strobe then writes that slot's identifier and enable.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, out_valid and terr_flag are 0 and every table slot is disabled. A packet whose identifier was held only in a table slot before the reset is dropped.
- R2: The identifier is bits [4:0] of header byte 1 (bits 12:8) joined with header byte 2 (bits 7:0). A packet passes when its identifier equals a dedicated register (ded_pid slice k, bits k*13+12:k*13, with k = 0..5) whose bit k in ded_en is 1. A dedicated register whose enable is 0 never passes a packet.
- R3: When grp_en is 1, a packet passes if (identifier AND grp_mask) equals (grp_pid AND grp_mask).
- R4: A pulse on tbl_idx_wr latches tbl_idx as the current slot. A later pulse on tbl_data_wr stores tbl_pid and tbl_en into that slot. A packet passes when its identifier equals the identifier of a slot whose enable is 1.
- R5: When null_en is 1, a packet with identifier 0x1FFF is dropped even if a filter matches it. When null_en is 0, such a packet is treated like any other.
- R6: When rx_en is 0 at the third header byte, the packet is dropped and terr_flag is not set by it.
- R7: A packet whose first byte is not 0x47 is dropped.
- R8: A packet with bit 7 of header byte 1 set is dropped. If rx_en is 1 and its first byte is 0x47, terr_flag is set and then stays at 1 until reset.
- R9: A passing packet appears on out_data as all of its bytes in order, with out_sync high only on byte 0. With contiguous input, each byte leaves 3 clock edges after the edge that samples it. Gaps in the input do not change the byte sequence. A dropped packet produces no output.
- R10: A start strobe that arrives before the third header byte abandons the unfinished header. None of its bytes is output, and the new packet is handled normally.
- R11: A packet that matches no enabled filter is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Byte qualifier |
| in_sync | input | 1 | First byte of a packet (with in_valid) |
| rx_en | input | 1 | Master receive enable |
| ded_pid | input | 78 | Six dedicated identifiers, 13 bits each |
| ded_en | input | 6 | Per-register enables for ded_pid |
| grp_pid | input | 13 | Group identifier value |
| grp_mask | input | 13 | Group compare mask |
| grp_en | input | 1 | Group filter enable |
| null_en | input | 1 | Drop identifier 0x1FFF |
| tbl_idx_wr | input | 1 | Latch tbl_idx as current slot |
| tbl_idx | input | 5 | Slot index |
| tbl_data_wr | input | 1 | Write current slot |
| tbl_pid | input | 13 | Slot identifier to write |
| tbl_en | input | 1 | Slot enable to write |
| out_data | output | 8 | Forwarded byte |
| out_valid | output | 1 | Forwarded byte qualifier |
| out_sync | output | 1 | First byte of a forwarded packet |
| terr_flag | output | 1 | Sticky transport-error flag |

## Verification
The pass or drop decision is registered on the edge that samples the third header byte. terr_flag therefore changes on that edge. The first output byte follows on the next edge, so a byte driven when the bench's cycle count is N appears on the output when the count is N+4. The bench samples on the falling edge and collects the whole output stream after each packet. It then waits a fixed drain of several cycles before comparing the stream byte by byte with the sequence its own model predicts. On one contiguous packet it also checks the exact cycle of the first output byte.

// File: rtl/ts_pid_pkg.sv
package ts_pid_pkg;
   localparam int PID_W    = 13;
   localparam int BYTE_W   = 8;
   localparam int NUM_DED  = 6;
   localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h47;
   localparam logic [PID_W-1:0]  NULL_PID  = 13'h1FFF;

   typedef logic [PID_W-1:0] pid_t;

   // slice order inside the dedicated identifier vector
   typedef enum logic [2:0] {
      DED_STREAM_A = 3'd0,
      DED_STREAM_B = 3'd1,
      DED_CLOCKREF = 3'd2,
      DED_PROGMAP  = 3'd3,
      DED_ENTMGMT  = 3'd4,
      DED_ENTCTRL  = 3'd5
   } ded_sel_e;
endpackage

// File: rtl/ts_pid_table.sv
module ts_pid_table
   import ts_pid_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       idx_wr,
   input  logic [SLOT_W-1:0]          idx_in,
   input  logic                       data_wr,
   input  pid_t                       pid_in,
   input  logic                       en_in,
   output logic [NUM_SLOTS*PID_W-1:0] slot_pid,
   output logic [NUM_SLOTS-1:0]       slot_en
);
   logic [SLOT_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_wr) idx_q <= idx_in;
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_pid[k*PID_W +: PID_W] <= '0;
            slot_en[k]                 <= 1'b0;
         end else if (data_wr && idx_q == SLOT_W'(k)) begin
            slot_pid[k*PID_W +: PID_W] <= pid_in;
            slot_en[k]                 <= en_in;
         end
      end
   end

   // R4
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_wr |=> $stable(idx_q));
endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match
   import ts_pid_pkg::*;
#(
   parameter int NUM_SLOTS = 32
)(
   input  pid_t                       pid,
   input  logic [NUM_DED*PID_W-1:0]   ded_pid,
   input  logic [NUM_DED-1:0]         ded_en,
   input  pid_t                       grp_pid,
   input  pid_t                       grp_mask,
   input  logic                       grp_en,
   input  logic [NUM_SLOTS*PID_W-1:0] slot_pid,
   input  logic [NUM_SLOTS-1:0]       slot_en,
   output logic                       hit,
   output logic                       is_null
);
   logic [NUM_DED-1:0]   ded_hit;
   logic [NUM_SLOTS-1:0] slot_hit;
   logic                 grp_hit;

   for (genvar k = 0; k < NUM_DED; k++) begin : g_ded
      assign ded_hit[k] = ded_en[k] && (ded_pid[k*PID_W +: PID_W] == pid);
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_tab
      assign slot_hit[k] = slot_en[k] && (slot_pid[k*PID_W +: PID_W] == pid);
   end

   assign grp_hit = grp_en && ((pid & grp_mask) == (grp_pid & grp_mask));
   assign hit     = (|ded_hit) || (|slot_hit) || grp_hit;
   assign is_null = (pid == NULL_PID);
endmodule

// File: rtl/ts_hold_fifo.sv
module ts_hold_fifo #(
   parameter int DW    = 9,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic [1:0]    rewind,
   input  logic [1:0]    rel_add,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wr_ptr, rd_ptr, rel_cnt, base, fill, held;
   logic          pop;

   assign base = wr_ptr - (AW+1)'(rewind);
   assign pop  = (rel_cnt != '0);
   assign fill = wr_ptr - rd_ptr;
   assign held = fill - rel_cnt;

   always_ff @(posedge clk) begin
      if (wr_en) mem[base[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         rel_cnt  <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         wr_ptr   <= base + (AW+1)'(wr_en);
         rd_ptr   <= rd_ptr + (AW+1)'(pop);
         rel_cnt  <= rel_cnt + (AW+1)'(rel_add) - (AW+1)'(pop);
         rd_valid <= pop;
         if (pop) rd_data <= mem[rd_ptr[AW-1:0]];
      end
   end

   // R9
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= (AW+1)'(DEPTH));
   // R9
   release_within_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_cnt <= fill);
   // R10
   rewind_unreleased_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind != 2'd0) |-> (held >= (AW+1)'(rewind)));
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
   import ts_pid_pkg::*;
#(
   parameter int NUM_SLOTS  = 32,
   parameter int PKT_LEN    = 188,
   parameter int FIFO_DEPTH = 8,
   localparam int SLOT_W    = $clog2(NUM_SLOTS),
   localparam int IDX_W     = $clog2(PKT_LEN),
   localparam int HI_W      = PID_W - BYTE_W
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [BYTE_W-1:0]        in_data,
   input  logic                     in_valid,
   input  logic                     in_sync,
   input  logic                     rx_en,
   input  logic [NUM_DED*PID_W-1:0] ded_pid,
   input  logic [NUM_DED-1:0]       ded_en,
   input  logic [PID_W-1:0]         grp_pid,
   input  logic [PID_W-1:0]         grp_mask,
   input  logic                     grp_en,
   input  logic                     null_en,
   input  logic                     tbl_idx_wr,
   input  logic [SLOT_W-1:0]        tbl_idx,
   input  logic                     tbl_data_wr,
   input  logic [PID_W-1:0]         tbl_pid,
   input  logic                     tbl_en,
   output logic [BYTE_W-1:0]        out_data,
   output logic                     out_valid,
   output logic                     out_sync,
   output logic                     terr_flag
);
   initial begin
      assert (PKT_LEN >= 4) else $error("packet length too short");
      assert (FIFO_DEPTH >= 8 && (FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0)
         else $error("hold queue depth must be a power of two, at least 8");
      assert (NUM_SLOTS >= 2) else $error("table needs two or more slots");
   end

   logic [IDX_W-1:0]  byte_idx;
   logic              in_pkt, pkt_pass;
   logic [1:0]        hdr_cnt;
   logic [BYTE_W-1:0] h0, h1;

   logic [NUM_SLOTS*PID_W-1:0] slot_pid;
   logic [NUM_SLOTS-1:0]       slot_en;
   pid_t                       pid_cur;
   logic                       hit, is_null, hdr_good, pass_now;

   logic          fifo_wr;
   logic [1:0]    fifo_rew, fifo_add;
   logic [BYTE_W:0] fifo_din, fifo_dout;

   ts_pid_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(tbl_idx_wr), .idx_in(tbl_idx),
      .data_wr(tbl_data_wr), .pid_in(tbl_pid), .en_in(tbl_en),
      .slot_pid(slot_pid), .slot_en(slot_en)
   );

   assign pid_cur = {h1[HI_W-1:0], in_data};

   ts_pid_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
      .pid(pid_cur), .ded_pid(ded_pid), .ded_en(ded_en),
      .grp_pid(grp_pid), .grp_mask(grp_mask), .grp_en(grp_en),
      .slot_pid(slot_pid), .slot_en(slot_en),
      .hit(hit), .is_null(is_null)
   );

   assign hdr_good = (h0 == SYNC_BYTE);
   assign pass_now = rx_en && hdr_good && !h1[BYTE_W-1] && hit && !(null_en && is_null);

   always_comb begin
      fifo_wr  = 1'b0;
      fifo_rew = 2'd0;
      fifo_add = 2'd0;
      fifo_din = {1'b0, in_data};
      if (in_valid) begin
         if (in_sync) begin
            fifo_wr  = 1'b1;
            fifo_rew = hdr_cnt;
            fifo_din = {1'b1, in_data};
         end else if (in_pkt) begin
            if (byte_idx == IDX_W'(1)) begin
               fifo_wr = 1'b1;
            end else if (byte_idx == IDX_W'(2)) begin
               if (pass_now) begin
                  fifo_wr  = 1'b1;
                  fifo_add = 2'd3;
               end else begin
                  fifo_rew = 2'd2;
               end
            end else if (pkt_pass) begin
               fifo_wr  = 1'b1;
               fifo_add = 2'd1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_idx  <= '0;
         in_pkt    <= 1'b0;
         pkt_pass  <= 1'b0;
         hdr_cnt   <= 2'd0;
         h0        <= '0;
         h1        <= '0;
         terr_flag <= 1'b0;
      end else if (in_valid) begin
         if (in_sync) begin
            in_pkt   <= 1'b1;
            byte_idx <= IDX_W'(1);
            hdr_cnt  <= 2'd1;
            pkt_pass <= 1'b0;
            h0       <= in_data;
         end else if (in_pkt) begin
            byte_idx <= byte_idx + IDX_W'(1);
            if (byte_idx == IDX_W'(1)) begin
               h1      <= in_data;
               hdr_cnt <= 2'd2;
            end
            if (byte_idx == IDX_W'(2)) begin
               hdr_cnt  <= 2'd0;
               pkt_pass <= pass_now;
               if (rx_en && hdr_good && h1[BYTE_W-1]) terr_flag <= 1'b1;
            end
            if (byte_idx == IDX_W'(PKT_LEN - 1)) begin
               in_pkt   <= 1'b0;
               pkt_pass <= 1'b0;
            end
         end
      end
   end

   ts_hold_fifo #(.DW(BYTE_W + 1), .DEPTH(FIFO_DEPTH)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fifo_wr), .wr_data(fifo_din),
      .rewind(fifo_rew), .rel_add(fifo_add),
      .rd_valid(out_valid), .rd_data(fifo_dout)
   );

   assign out_data = fifo_dout[BYTE_W-1:0];
   assign out_sync = fifo_dout[BYTE_W];

   // R8
   terr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      terr_flag |=> terr_flag);
   // R6
   terr_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(terr_flag) |-> $past(rx_en));
   // R9
   sync_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sync |-> out_valid);
endmodule

// File: tb/tb_ts_pid_filter.sv
module tb_ts_pid_filter;
   localparam int PLEN = 188;
   localparam int NS   = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0, in_sync = 1'b0;
   logic        rx_en = 1'b1;
   logic [77:0] ded_pid = '0;
   logic [5:0]  ded_en = '0;
   logic [12:0] grp_pid = '0, grp_mask = '0;
   logic        grp_en = 1'b0, null_en = 1'b0;
   logic        tbl_idx_wr = 1'b0, tbl_data_wr = 1'b0, tbl_en = 1'b0;
   logic [4:0]  tbl_idx = '0;
   logic [12:0] tbl_pid = '0;
   logic [7:0]  out_data;
   logic        out_valid, out_sync, terr_flag;

   ts_pid_filter dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_sync(in_sync),
      .rx_en(rx_en), .ded_pid(ded_pid), .ded_en(ded_en), .grp_pid(grp_pid),
      .grp_mask(grp_mask), .grp_en(grp_en), .null_en(null_en),
      .tbl_idx_wr(tbl_idx_wr), .tbl_idx(tbl_idx), .tbl_data_wr(tbl_data_wr),
      .tbl_pid(tbl_pid), .tbl_en(tbl_en), .out_data(out_data), .out_valid(out_valid),
      .out_sync(out_sync), .terr_flag(terr_flag)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0, bad = 0;
   logic [12:0] m_spid [NS];
   bit          m_sen  [NS];
   bit          exp_terr = 1'b0;
   logic [7:0]  exp_d [400];
   bit          exp_s [400];
   int          exp_n = 0;
   logic [7:0]  got_d [400];
   bit          got_s [400];
   int          n_out = 0;
   int          t_in = 0, t_first = 0;

   always @(negedge clk) begin
      if (out_valid) begin
         if (n_out == 0) t_first = cyc;
         if (n_out < 400) begin
            got_d[n_out] = out_data;
            got_s[n_out] = out_sync;
         end
         n_out++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic bit model_pass(input logic [7:0] b0, input logic [7:0] b1,
                                     input logic [7:0] b2);
      logic [12:0] p = {b1[4:0], b2};
      bit h = 1'b0;
      for (int k = 0; k < 6; k++)
         if (ded_en[k] && ded_pid[k*13 +: 13] == p) h = 1'b1;
      if (grp_en && ((p & grp_mask) == (grp_pid & grp_mask))) h = 1'b1;
      for (int j = 0; j < NS; j++)
         if (m_sen[j] && m_spid[j] == p) h = 1'b1;
      return rx_en && b0 == 8'h47 && !b1[7] && h && !(null_en && p == 13'h1FFF);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int j = 0; j < NS; j++) begin
         m_sen[j]  = 1'b0;
         m_spid[j] = '0;
      end
      exp_terr = 1'b0;
   endtask

   task automatic tbl_write(input int j, input logic [12:0] p, input bit en);
      @(negedge clk);
      tbl_idx_wr = 1'b1; tbl_idx = 5'(j);
      @(negedge clk);
      tbl_idx_wr = 1'b0; tbl_data_wr = 1'b1; tbl_pid = p; tbl_en = en;
      @(negedge clk);
      tbl_data_wr = 1'b0;
      m_spid[j] = p; m_sen[j] = en;
   endtask

   task automatic send_pkt(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] seed, input int gap);
      bit p = model_pass(b0, b1, b2);
      if (rx_en && b0 == 8'h47 && b1[7]) exp_terr = 1'b1;
      for (int i = 0; i < PLEN; i++) begin
         logic [7:0] v = (i == 0) ? b0 : (i == 1) ? b1 : (i == 2) ? b2 : 8'(i * 7 + seed);
         if (p) begin
            exp_d[exp_n] = v; exp_s[exp_n] = (i == 0); exp_n++;
         end
         @(negedge clk);
         if (i == 0) t_in = cyc;
         in_valid = 1'b1; in_sync = (i == 0); in_data = v;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sync = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_sync = 1'b0;
   endtask

   task automatic send_pid(input logic [12:0] p, input logic [7:0] seed);
      send_pkt(8'h47, {3'b000, p[12:8]}, p[7:0], seed, 0);
   endtask

   task automatic check_stream(input string req, input int want_n);
      int mism = 0;
      repeat (8) @(negedge clk);
      chk(n_out == want_n && exp_n == want_n, req, n_out, want_n);
      for (int i = 0; i < exp_n && i < n_out; i++)
         if (got_d[i] !== exp_d[i] || got_s[i] !== exp_s[i]) mism++;
      if (want_n > 0) chk(mism == 0, req, mism, 0);
      chk(terr_flag === exp_terr, req, int'(terr_flag), int'(exp_terr));
      n_out = 0; exp_n = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
      chk(terr_flag === 1'b0, "R1", int'(terr_flag), 0);

      // R11 nothing enabled
      send_pid(13'h0100, 8'd1);
      check_stream("R11", 0);

      // R2 each dedicated register alone
      for (int k = 0; k < 6; k++) ded_pid[k*13 +: 13] = 13'(13'h0100 + k * 13'h0111);
      for (int k = 0; k < 6; k++) begin
         ded_en = 6'(1 << k);
         send_pid(13'(13'h0100 + k * 13'h0111), 8'(k));
         check_stream("R2", PLEN);
         send_pid(13'(13'h0100 + ((k + 1) % 6) * 13'h0111), 8'(k));
         check_stream("R2", 0);
      end
      // R9 latency on contiguous input, then back-to-back pair
      ded_en = 6'b000001;
      send_pid(13'h0100, 8'd9);
      chk(t_first - t_in == 4, "R9", t_first - t_in, 4);
      check_stream("R9", PLEN);
      send_pid(13'h0100, 8'd3);
      send_pid(13'h0100, 8'd4);
      check_stream("R9", 2 * PLEN);
      // R9 gapped input
      send_pkt(8'h47, 8'h01, 8'h00, 8'd5, 2);
      check_stream("R9", PLEN);
      ded_en = '0;

      // R3 group filter
      grp_en = 1'b1; grp_pid = 13'h0A50; grp_mask = 13'h1FF0;
      send_pid(13'h0A5F, 8'd6);  check_stream("R3", PLEN);
      send_pid(13'h0A4F, 8'd6);  check_stream("R3", 0);
      send_pid(13'h1A50, 8'd6);  check_stream("R3", 0);
      grp_en = 1'b0;
      send_pid(13'h0A5F, 8'd6);  check_stream("R3", 0);

      // R4 table slots, even ones enabled
      for (int j = 0; j < NS; j++) tbl_write(j, 13'(13'h0800 + j * 3), (j % 2) == 0);
      for (int j = 0; j < NS; j++) begin
         send_pid(13'(13'h0800 + j * 3), 8'(j));
         check_stream("R4", (j % 2) == 0 ? PLEN : 0);
      end
      tbl_write(0, 13'h0800, 1'b0);
      send_pid(13'h0800, 8'd2); check_stream("R4", 0);

      // R5 null packets
      tbl_write(1, 13'h1FFF, 1'b1);
      null_en = 1'b1;
      send_pid(13'h1FFF, 8'd7); check_stream("R5", 0);
      null_en = 1'b0;
      send_pid(13'h1FFF, 8'd7); check_stream("R5", PLEN);

      // R7 bad sync byte
      send_pkt(8'h46, 8'h08, 8'h06, 8'd8, 0);
      check_stream("R7", 0);

      // R10 restart during header
      @(negedge clk); in_valid = 1'b1; in_sync = 1'b1; in_data = 8'h47;
      @(negedge clk); in_sync = 1'b0; in_data = 8'h08;
      send_pkt(8'h47, 8'h08, 8'h06, 8'd11, 0);
      check_stream("R10", PLEN);

      // R8 transport error bit
      send_pkt(8'h47, 8'h88, 8'h06, 8'd12, 0);
      check_stream("R8", 0);
      send_pid(13'h0806, 8'd13);
      check_stream("R8", PLEN);

      // R1 reset clears flag and table
      do_reset();
      @(negedge clk);
      chk(terr_flag === 1'b0, "R1", int'(terr_flag), 0);
      send_pid(13'h0806, 8'd14);
      check_stream("R1", 0);

      // R6 receive disabled
      ded_en = 6'b000001;
      rx_en = 1'b0;
      send_pkt(8'h47, 8'h81, 8'h00, 8'd15, 0);
      check_stream("R6", 0);
      send_pid(13'h0100, 8'd16);
      check_stream("R6", 0);
      rx_en = 1'b1;
      send_pid(13'h0100, 8'd17);
      check_stream("R6", PLEN);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule